// File: doc/BRIEF.md
# Guarded Return-Target Stack

This block keeps return targets in storage of their own, separate from the data stack that holds locals and buffers, so a buffer that runs past its end cannot overwrite a return target. The instruction decoder drives four request lines into it: subroutine entry (which saves the return address without being asked), subroutine exit (which takes the top entry as the next program counter), and one dedicated save and one dedicated restore instruction. No other path can write into the storage.

A dedicated save carries a type tag beside its value. The block accepts it only when the tag marks the value as an address. Any other tag is refused with a fault. The block also raises pulsed faults when the stack fills up, when it runs empty, and when more than one request arrives in the same cycle. Every output is registered, so results and faults appear on the clock edge after the request that caused them.

Top module: `ret_guard_stack`

## Requirements
- R1: While `rst` is high at a clock edge, the stack is emptied and every output is cleared. After that edge, `depth` is 0 and the two target outputs and all fault outputs are 0, whatever the request inputs were.
- R2: An accepted save increments `depth` by one at the next edge. A save is accepted from `call_req` (value `call_addr`) or from a dedicated save (value `push_val`).
- R3: A save attempted while `depth` equals DEPTH raises `flt_overflow` for one cycle. The contents and `depth` stay unchanged.
- R4: An exit request on a non-empty stack removes the top entry. In the next cycle it drives that entry on `tgt_addr` with `tgt_valid` high, in last-in first-out order.
- R5: An exit or dedicated restore on an empty stack raises `flt_underflow` for one cycle. `tgt_valid` stays low and `tgt_addr` stays 0.
- R6: A dedicated save is accepted only when `push_tag` equals 2, the address tag. The other codes are 0 null, 1 instruction, 3 plain value and 4 reference, and any of them raises `flt_badtag` with no change to the stack. The tag check comes before the full check, so a badly tagged save on a full stack raises only `flt_badtag`.
- R7: A dedicated restore on a non-empty stack behaves like an exit. It removes the top entry and presents it on `tgt_addr` with `tgt_valid` high.
- R8: Only one request runs per cycle, in the priority order exit, entry, restore, save. When more than one request line is high, `flt_illegal` pulses for one cycle. An entry that arrives together with an exit is therefore dropped.
- R9: Each fault is high for exactly the cycle after its request and only then. `tgt_addr` is 0 in every cycle where `tgt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Subroutine entry; saves `call_addr` |
| ret_req | input | 1 | Subroutine exit; restores the top entry as the target |
| push_req | input | 1 | Dedicated save instruction |
| pop_req | input | 1 | Dedicated restore instruction |
| call_addr | input | AW | Return address for an entry |
| push_val | input | AW | Value for a dedicated save |
| push_tag | input | TAG_W | Type tag of `push_val` |
| tgt_valid | output | 1 | Restored target present |
| tgt_addr | output | AW | Restored target; 0 when not valid |
| depth | output | CW | Number of stored entries |
| flt_overflow | output | 1 | Save refused, stack full |
| flt_underflow | output | 1 | Restore refused, stack empty |
| flt_badtag | output | 1 | Dedicated save refused, tag is not the address tag |
| flt_illegal | output | 1 | More than one request line high |

## Verification
The bench builds the block with DEPTH=4 and AW=16. With only four entries, random traffic hits the full and empty limits many times, so overflow, underflow and the ordering of the tag check against the full check are all exercised often. The address width is kept narrow so that the values are easy to tell apart when a LIFO-order error shows up in the log. Requests that overlap, and resets that arrive in the middle of traffic, are mixed into the random phase.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_RET  = 3'd1,
    OP_CALL = 3'd2,
    OP_POP  = 3'd3,
    OP_PUSH = 3'd4
  } ras_op_e;
endpackage

// File: rtl/ras_arbiter.sv
module ras_arbiter
  import ras_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          call_req,
  input  logic          ret_req,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [AW-1:0] call_addr,
  input  logic [AW-1:0] push_val,
  output ras_op_e       op,
  output logic [AW-1:0] wr_val,
  output logic          multi
);
  logic [2:0] nreq;

  always_comb begin
    nreq  = 3'(call_req) + 3'(ret_req) + 3'(push_req) + 3'(pop_req);
    multi = (nreq > 3'd1);
    if (ret_req)       op = OP_RET;
    else if (call_req) op = OP_CALL;
    else if (pop_req)  op = OP_POP;
    else if (push_req) op = OP_PUSH;
    else               op = OP_NONE;
    wr_val = (op == OP_CALL) ? call_addr : push_val;
  end
endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TAG_W    = 3,
  parameter int ADDR_TAG = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  ras_op_e          op,
  input  logic [TAG_W-1:0] tag,
  output logic [CW-1:0]    count,
  output logic             wr_en,
  output logic [PW-1:0]    wr_idx,
  output logic             rd_en,
  output logic [PW-1:0]    rd_idx,
  output logic             ovf,
  output logic             unf,
  output logic             bad
);
  logic          full, empty, save_try, rest_try, tag_ok;
  logic [CW-1:0] below;

  always_comb begin
    full     = (count == CW'(DEPTH));
    empty    = (count == '0);
    tag_ok   = (tag == TAG_W'(ADDR_TAG));
    save_try = (op == OP_CALL) || (op == OP_PUSH && tag_ok);
    rest_try = (op == OP_RET) || (op == OP_POP);
    bad      = (op == OP_PUSH) && !tag_ok;
    wr_en    = save_try && !full;
    ovf      = save_try && full;
    rd_en    = rest_try && !empty;
    unf      = rest_try && empty;
    below    = count - CW'(1);
    wr_idx   = count[PW-1:0];
    rd_idx   = below[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (wr_en) count <= count + CW'(1);
    else if (rd_en) count <= count - CW'(1);
  end

  // R3: the pointer never passes the array size
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R3: a refused save leaves the fill level alone
  assert_full_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ovf |=> $stable(count));
  // R2: an accepted save grows the fill level by one
  assert_save_grow_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> count == $past(count) + CW'(1));
  // R5: an empty restore keeps the stack empty
  assert_empty_hold_R5: assert property (@(posedge clk) disable iff (rst)
    unf |=> count == '0);
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [PW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [AW-1:0] rd_data
);
  logic [AW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? mem[rd_idx] : '0;
    end
  end

  // R9: no target value leaks out while it is not valid
  assert_tgt_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> rd_data == '0);
endmodule

// File: rtl/ret_guard_stack.sv
module ret_guard_stack
  import ras_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int AW       = 32,
  parameter int TAG_W    = 3,
  parameter int ADDR_TAG = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             call_req,
  input  logic             ret_req,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic [AW-1:0]    call_addr,
  input  logic [AW-1:0]    push_val,
  input  logic [TAG_W-1:0] push_tag,
  output logic             tgt_valid,
  output logic [AW-1:0]    tgt_addr,
  output logic [CW-1:0]    depth,
  output logic             flt_overflow,
  output logic             flt_underflow,
  output logic             flt_badtag,
  output logic             flt_illegal
);
  ras_op_e       op;
  logic [AW-1:0] wr_val;
  logic          multi, wr_en, rd_en, ovf, unf, bad;
  logic [PW-1:0] wr_idx, rd_idx;

  ras_arbiter #(.AW(AW)) u_arb (
    .call_req (call_req),
    .ret_req  (ret_req),
    .push_req (push_req),
    .pop_req  (pop_req),
    .call_addr(call_addr),
    .push_val (push_val),
    .op       (op),
    .wr_val   (wr_val),
    .multi    (multi)
  );

  ras_ptr_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_TAG(ADDR_TAG)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .tag   (push_tag),
    .count (depth),
    .wr_en (wr_en),
    .wr_idx(wr_idx),
    .rd_en (rd_en),
    .rd_idx(rd_idx),
    .ovf   (ovf),
    .unf   (unf),
    .bad   (bad)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_val),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .rd_valid(tgt_valid),
    .rd_data (tgt_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_overflow  <= 1'b0;
      flt_underflow <= 1'b0;
      flt_badtag    <= 1'b0;
      flt_illegal   <= 1'b0;
    end else begin
      flt_overflow  <= ovf;
      flt_underflow <= unf;
      flt_badtag    <= bad;
      flt_illegal   <= multi;
    end
  end

  // R6: a refused tag never moves the fill level
  assert_badtag_hold_R6: assert property (@(posedge clk) disable iff (rst)
    flt_badtag |-> depth == $past(depth));
  // R8: entry together with exit is flagged and only the exit runs
  assert_call_ret_R8: assert property (@(posedge clk) disable iff (rst)
    (call_req && ret_req) |=> flt_illegal && !flt_overflow);
  // R5: an underflow never comes with a valid target
  assert_unf_novalid_R5: assert property (@(posedge clk) disable iff (rst)
    flt_underflow |-> !tgt_valid);
endmodule

// File: tb/ret_guard_stack_tb.sv
`timescale 1ns/1ps
module ret_guard_stack_tb;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int TW    = 3;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic call_req = 0, ret_req = 0, push_req = 0, pop_req = 0;
  logic [AW-1:0] call_addr = '0, push_val = '0;
  logic [TW-1:0] push_tag = '0;
  logic tgt_valid, flt_overflow, flt_underflow, flt_badtag, flt_illegal;
  logic [AW-1:0] tgt_addr;
  logic [CW-1:0] depth;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [AW-1:0] model_q[$];
  logic          e_tv, e_ov, e_un, e_bt, e_il;
  logic [AW-1:0] e_ta;

  always #2 clk = ~clk;

  ret_guard_stack #(.DEPTH(DEPTH), .AW(AW), .TAG_W(TW), .ADDR_TAG(2)) u_dut (
    .clk(clk), .rst(rst),
    .call_req(call_req), .ret_req(ret_req), .push_req(push_req), .pop_req(pop_req),
    .call_addr(call_addr), .push_val(push_val), .push_tag(push_tag),
    .tgt_valid(tgt_valid), .tgt_addr(tgt_addr), .depth(depth),
    .flt_overflow(flt_overflow), .flt_underflow(flt_underflow),
    .flt_badtag(flt_badtag), .flt_illegal(flt_illegal)
  );

  task automatic chk(string req, string ctx, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (%s) at %0t: actual %0h expected %0h", req, ctx, $time, act, exp);
    end
  endtask

  task automatic compare(string ctx);
    vectors++;
    chk("R2", {ctx, " depth"}, 32'(depth), 32'(model_q.size()));
    chk("R4", {ctx, " tgt_valid"}, 32'(tgt_valid), 32'(e_tv));
    chk("R9", {ctx, " tgt_addr"}, 32'(tgt_addr), 32'(e_ta));
    chk("R3", {ctx, " overflow"}, 32'(flt_overflow), 32'(e_ov));
    chk("R5", {ctx, " underflow"}, 32'(flt_underflow), 32'(e_un));
    chk("R6", {ctx, " badtag"}, 32'(flt_badtag), 32'(e_bt));
    chk("R8", {ctx, " illegal"}, 32'(flt_illegal), 32'(e_il));
  endtask

  // Called at a falling edge: drive, predict, wait one rising edge, compare.
  task automatic step(bit r_s, bit c, bit r, bit pu, bit po,
                      logic [AW-1:0] ca, logic [AW-1:0] pv, logic [TW-1:0] tg,
                      string ctx);
    int n;
    rst = r_s; call_req = c; ret_req = r; push_req = pu; pop_req = po;
    call_addr = ca; push_val = pv; push_tag = tg;
    e_tv = 0; e_ta = '0; e_ov = 0; e_un = 0; e_bt = 0; e_il = 0;
    n = int'(c) + int'(r) + int'(pu) + int'(po);
    if (r_s) begin
      model_q.delete();
    end else begin
      e_il = (n > 1);
      if (r || (!c && po)) begin
        if (model_q.size() == 0) e_un = 1;
        else begin e_tv = 1; e_ta = model_q.pop_back(); end
      end else if (c) begin
        if (model_q.size() == DEPTH) e_ov = 1;
        else model_q.push_back(ca);
      end else if (pu) begin
        if (tg != 3'd2) e_bt = 1;
        else if (model_q.size() == DEPTH) e_ov = 1;
        else model_q.push_back(pv);
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(ctx);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset dominates any request
    step(1, 1, 0, 1, 0, 16'h1111, 16'h2222, 3'd2, "R1 reset");
    step(1, 0, 1, 0, 1, 16'h0, 16'h0, 3'd0, "R1 reset");
    // R2/R3: entries beyond the limit
    for (int i = 0; i < DEPTH + 2; i++)
      step(0, 1, 0, 0, 0, 16'h1000 + 16'(i), 16'h0, 3'd0, "R2 R3 fill");
    // R9: fault gone in the idle cycle after
    step(0, 0, 0, 0, 0, 16'h0, 16'h0, 3'd0, "R9 idle after overflow");
    // R4/R5: drain past empty
    for (int i = 0; i < DEPTH + 2; i++)
      step(0, 0, 1, 0, 0, 16'h0, 16'h0, 3'd0, "R4 R5 drain");
    step(0, 0, 0, 0, 1, 16'h0, 16'h0, 3'd0, "R5 restore empty");
    // R6: every tag code on a dedicated save
    for (int t = 0; t < 5; t++)
      step(0, 0, 0, 1, 0, 16'h0, 16'hA000 + 16'(t), 3'(t), "R6 tag sweep");
    // R7: dedicated restore returns the address-tagged value
    step(0, 0, 0, 0, 1, 16'h0, 16'h0, 3'd0, "R7 restore");
    // R6: bad tag on a full stack reports only the tag fault
    for (int i = 0; i < DEPTH; i++)
      step(0, 0, 0, 1, 0, 16'h0, 16'hB000 + 16'(i), 3'd2, "R6 fill");
    step(0, 0, 0, 1, 0, 16'h0, 16'hBEEF, 3'd3, "R6 full bad tag");
    step(0, 0, 0, 1, 0, 16'h0, 16'hBEEF, 3'd2, "R3 full good tag");
    // R8: overlapping requests
    step(0, 1, 1, 0, 0, 16'hC0DE, 16'h0, 3'd0, "R8 call with ret");
    step(0, 1, 0, 1, 1, 16'hC1DE, 16'hC2DE, 3'd2, "R8 call pop push");
    step(0, 0, 0, 1, 1, 16'h0, 16'hC3DE, 3'd2, "R8 pop push");
    step(0, 1, 1, 1, 1, 16'hC4DE, 16'hC5DE, 3'd2, "R8 all four");
    step(0, 0, 0, 0, 0, 16'h0, 16'h0, 3'd0, "R9 idle");
    // random traffic with occasional resets
    for (int k = 0; k < 4000; k++) begin
      int sel;
      sel = int'($urandom_range(0, 99));
      step(sel == 0,
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0,
           16'($urandom), 16'($urandom),
           ($urandom_range(0, 2) == 0) ? 3'($urandom_range(0, 7)) : 3'd2,
           "random R1 R2 R3 R4 R5 R6 R7 R8 R9");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule